// File: doc/BRIEF.md
# ADC Scan and Trigger Controller

This block sits in front of an analog-to-digital converter core and decides when a scan begins, which channels are converted, and how each result is tagged for storage. It holds one 16-bit control word, written and read over a plain register bus. A scan can be started by software, by a synchronous trigger pulse, or by a falling edge on an external trigger pin that is resynchronised inside the block. For each channel in the scan, the block issues a start request and a channel number to the converter. It then waits for the converter's done strobe and passes the result on with a channel number and tag bits. Downstream storage uses those tags to choose the destination register.

Three scan modes are supported: single, group, and continuous. In group mode, group A scans are started by the main trigger and group B scans by a separate trigger input. An optional duplication mode replaces the group A channel mask with one selected channel. Successive duplication scans are then tagged first, second, first, and so on, so that the second result goes to a duplicate register. Scan-end interrupts are one-cycle pulses, one for group A or ungrouped scans and one for group B scans. Each is gated by its own enable bit.

Top module: `adc_scan_ctrl`

## Requirements
- R1: After reset the control word reads 16'h0000, no conversion is requested, and no interrupt is raised.
- R2: Control bits 5, 10 and 11 always read back as 0, whatever was written to them.
- R3: Bits 14:13 select the scan mode: 00 single, 01 group, 10 continuous. A write carrying 11 in that field leaves the stored mode unchanged.
- R4: Writing 1 to bit 15 while no scan is running starts a group A scan, even when bit 9 is 0. Bit 15 reads 1 while that scan runs. It clears by itself when a single-mode or group-mode group A scan ends. Writing 0 to bit 15 aborts any scan: no further results and no interrupt follow.
- R5: When a group A or ungrouped scan ends, irq_scan_end pulses for one cycle only if bit 12 is 1. When a group B scan ends, irq_grpb_end pulses only if bit 6 is 1.
- R6: With bit 9 at 0, neither trig_sync, trig_grp_b nor ext_trig_n starts a scan.
- R7: With bits 9=1 and 8=0, a trig_sync pulse starts a scan and ext_trig_n edges are ignored. With bit 8=1, trig_sync is ignored.
- R8: With bits 9 and 8 both set, a falling edge on ext_trig_n starts a scan only after the pin has been seen high while both bits were set. If the pin is already low when the bits are set, no scan starts until the pin goes high and then low again.
- R9: ext_trig_n passes through a two-flop synchroniser. A low level held for 2 clock cycles is recognised, and bit 15 reads 1 within 4 cycles of the falling edge.
- R10: With bit 7 set, a group A scan converts only the channel whose index is in bits 4:0, and mask_a is ignored. Successive such scans give res_dup = 0, then 1, then 0, and so on.
- R11: A write does not change bits 4:0 if bit 15 already reads 1, or if the written word has bit 15 set.
- R12: In group mode (01), a trig_grp_b pulse with bit 9 set starts a group B scan of mask_b. Its results carry res_grp_b=1 and res_dup=0 whatever the value of bit 7. Group A scans in group mode still use the duplication behaviour.
- R13: The first/second duplication toggle returns to "first" when bit 7 is 0, and on any register write whose bit 15 is 0.
- R14: Channels in a scan are converted in ascending index order. conv_start is never asserted in two consecutive cycles, and the next request waits for the previous conv_done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Control word write strobe |
| reg_wdata | input | 16 | Control word write data |
| reg_rdata | output | 16 | Control word readback, bit 15 is live scan status |
| trig_sync | input | 1 | Synchronous trigger pulse for group A |
| trig_grp_b | input | 1 | Synchronous trigger pulse for group B |
| ext_trig_n | input | 1 | Asynchronous external trigger pin, active falling edge |
| mask_a | input | NCH | Group A / ungrouped channel mask |
| mask_b | input | NCH | Group B channel mask |
| conv_start | output | 1 | One-cycle conversion request |
| conv_chan | output | 5 | Channel index for the request |
| conv_done | input | 1 | Converter done strobe |
| conv_result | input | RES_W | Converter result, valid with conv_done |
| res_valid | output | 1 | Result strobe |
| res_chan | output | 5 | Channel of the result |
| res_data | output | RES_W | Result value |
| res_dup | output | 1 | Result belongs in the duplication register |
| res_grp_b | output | 1 | Result belongs to a group B scan |
| irq_scan_end | output | 1 | Group A / ungrouped scan-end interrupt pulse |
| irq_grpb_end | output | 1 | Group B scan-end interrupt pulse |

## Verification
A corrupted remaining-channel mask or current-channel register appears at the very next result: an unexpected, missing or out-of-order channel on res_chan. A stuck or wrongly reset duplication toggle shows up within one or two trigger scans as a wrong res_dup value. A wrong synchroniser or arming state shows up as a missing or spurious rise of bit 15 a few cycles after a pin edge. A wrong control field shows up on the first readback after the write. A fault in the end-of-scan path shows up as a wrong count of interrupt pulses by the time bit 15 has cleared.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;

    localparam int DCH_W   = 5;
    localparam int MAX_CH  = 32;

    localparam int B_GBIE  = 6;
    localparam int B_DBL   = 7;
    localparam int B_EXT   = 8;
    localparam int B_TEN   = 9;
    localparam int B_IE    = 12;
    localparam int B_MLO   = 13;
    localparam int B_MHI   = 14;
    localparam int B_START = 15;

    typedef enum logic [1:0] {
        MODE_SINGLE = 2'b00,
        MODE_GROUP  = 2'b01,
        MODE_CONT   = 2'b10,
        MODE_BAD    = 2'b11
    } scan_mode_e;

    typedef struct packed {
        logic [DCH_W-1:0] dbl_ch;
        logic             gb_ie;
        logic             dbl_en;
        logic             src_ext;
        logic             trig_en;
        logic             ie;
        scan_mode_e       mode;
    } ctl_t;

    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_ISSUE = 2'd1,
        SQ_WAIT  = 2'd2
    } seq_st_e;

    function automatic logic [DCH_W-1:0] lowest_idx(input logic [MAX_CH-1:0] m);
        lowest_idx = '0;
        for (int i = MAX_CH - 1; i >= 0; i--) begin
            if (m[i]) lowest_idx = DCH_W'(i);
        end
    endfunction

    function automatic logic [15:0] pack_ctl(input ctl_t c, input logic start);
        pack_ctl = {start, c.mode, c.ie, 2'b00, c.trig_en, c.src_ext,
                    c.dbl_en, c.gb_ie, 1'b0, c.dbl_ch};
    endfunction

endpackage

// File: rtl/adc_ctl_reg.sv
module adc_ctl_reg
    import adc_scan_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [15:0] wr_data,
    input  logic        start_now,
    output ctl_t        ctl
);

    logic unused_rsv;
    assign unused_rsv = ^{wr_data[11:10], wr_data[5], wr_data[B_START]};

    logic mode_ok;
    logic ch_ok;
    assign mode_ok = (wr_data[B_MHI:B_MLO] != MODE_BAD);
    assign ch_ok   = !start_now && !wr_data[B_START];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl <= '0;
        end else if (wr_en) begin
            ctl.gb_ie   <= wr_data[B_GBIE];
            ctl.dbl_en  <= wr_data[B_DBL];
            ctl.src_ext <= wr_data[B_EXT];
            ctl.trig_en <= wr_data[B_TEN];
            ctl.ie      <= wr_data[B_IE];
            if (mode_ok) ctl.mode <= scan_mode_e'(wr_data[B_MHI:B_MLO]);
            if (ch_ok)   ctl.dbl_ch <= wr_data[DCH_W-1:0];
        end
    end

endmodule

// File: rtl/adc_trig_det.sv
module adc_trig_det (
    input  logic clk,
    input  logic rst,
    input  logic pin_n,
    input  logic trig_pulse,
    input  logic trig_en,
    input  logic src_ext,
    output logic trig_a
);

    logic s1_q, s2_q, s3_q;
    logic arm_q;
    logic en_async;
    logic fall;

    assign en_async = trig_en && src_ext;
    assign fall     = s3_q && !s2_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q  <= 1'b1;
            s2_q  <= 1'b1;
            s3_q  <= 1'b1;
            arm_q <= 1'b0;
        end else begin
            s1_q  <= pin_n;
            s2_q  <= s1_q;
            s3_q  <= s2_q;
            arm_q <= en_async && (arm_q || s2_q);
        end
    end

    always_comb begin
        if (!trig_en)     trig_a = 1'b0;
        else if (src_ext) trig_a = arm_q && fall;
        else              trig_a = trig_pulse;
    end

endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
    import adc_scan_pkg::*;
#(
    parameter int NCH   = 16,
    parameter int RES_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  ctl_t             ctl,
    input  logic             wr_en,
    input  logic             sw_start,
    input  logic             sw_stop,
    input  logic             trig_a,
    input  logic             trig_b,
    input  logic [NCH-1:0]   mask_a,
    input  logic [NCH-1:0]   mask_b,
    input  logic             conv_done,
    input  logic [RES_W-1:0] conv_result,
    output logic             conv_start,
    output logic [DCH_W-1:0] conv_chan,
    output logic             res_valid,
    output logic [DCH_W-1:0] res_chan,
    output logic [RES_W-1:0] res_data,
    output logic             res_dup,
    output logic             res_grp_b,
    output logic             irq_scan_end,
    output logic             irq_grpb_end,
    output logic             start_flag
);

    seq_st_e          st_q;
    logic [NCH-1:0]   remain_q;
    logic [DCH_W-1:0] cur_q;
    logic             grp_b_q;
    logic             second_q;
    logic             start_q;

    logic [NCH-1:0]   mask_a_eff;
    logic [NCH-1:0]   clr_bit;
    logic [DCH_W-1:0] nxt;
    logic             idle, empty, go_a, go_b, finish, dbl_act, restart;

    always_comb begin
        for (int i = 0; i < NCH; i++) begin
            mask_a_eff[i] = ctl.dbl_en ? (ctl.dbl_ch == DCH_W'(i)) : mask_a[i];
            clr_bit[i]    = (cur_q == DCH_W'(i));
        end
    end

    assign nxt     = lowest_idx(MAX_CH'(remain_q));
    assign idle    = (st_q == SQ_IDLE);
    assign empty   = (remain_q == '0);
    assign go_a    = idle && (sw_start || (!wr_en && trig_a));
    assign go_b    = idle && !wr_en && !trig_a && trig_b && ctl.trig_en
                     && (ctl.mode == MODE_GROUP);
    assign finish  = (st_q == SQ_ISSUE) && empty && !sw_stop;
    assign dbl_act = ctl.dbl_en && !grp_b_q;
    assign restart = !grp_b_q && (ctl.mode == MODE_CONT);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= SQ_IDLE;
            remain_q <= '0;
            cur_q    <= '0;
            grp_b_q  <= 1'b0;
            start_q  <= 1'b0;
        end else if (sw_stop) begin
            st_q    <= SQ_IDLE;
            start_q <= 1'b0;
        end else begin
            case (st_q)
                SQ_IDLE: begin
                    if (go_a) begin
                        remain_q <= mask_a_eff;
                        grp_b_q  <= 1'b0;
                        start_q  <= 1'b1;
                        st_q     <= SQ_ISSUE;
                    end else if (go_b) begin
                        remain_q <= mask_b;
                        grp_b_q  <= 1'b1;
                        st_q     <= SQ_ISSUE;
                    end
                end
                SQ_ISSUE: begin
                    if (empty) begin
                        if (restart) begin
                            remain_q <= mask_a_eff;
                        end else begin
                            st_q    <= SQ_IDLE;
                            start_q <= 1'b0;
                        end
                    end else begin
                        cur_q <= nxt;
                        st_q  <= SQ_WAIT;
                    end
                end
                SQ_WAIT: begin
                    if (conv_done) begin
                        remain_q <= remain_q & ~clr_bit;
                        st_q     <= SQ_ISSUE;
                    end
                end
                default: st_q <= SQ_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst || sw_stop || !ctl.dbl_en) second_q <= 1'b0;
        else if (finish && dbl_act)        second_q <= !second_q;
    end

    assign conv_start   = (st_q == SQ_ISSUE) && !empty && !sw_stop;
    assign conv_chan    = nxt;
    assign res_valid    = (st_q == SQ_WAIT) && conv_done && !sw_stop;
    assign res_chan     = cur_q;
    assign res_data     = conv_result;
    assign res_dup      = dbl_act && second_q;
    assign res_grp_b    = grp_b_q;
    assign irq_scan_end = finish && !grp_b_q && ctl.ie;
    assign irq_grpb_end = finish && grp_b_q && ctl.gb_ie;
    assign start_flag   = start_q;

endmodule

// File: rtl/adc_scan_ctrl.sv
module adc_scan_ctrl
    import adc_scan_pkg::*;
#(
    parameter int NCH   = 16,
    parameter int RES_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_wr,
    input  logic [15:0]      reg_wdata,
    output logic [15:0]      reg_rdata,
    input  logic             trig_sync,
    input  logic             trig_grp_b,
    input  logic             ext_trig_n,
    input  logic [NCH-1:0]   mask_a,
    input  logic [NCH-1:0]   mask_b,
    output logic             conv_start,
    output logic [4:0]       conv_chan,
    input  logic             conv_done,
    input  logic [RES_W-1:0] conv_result,
    output logic             res_valid,
    output logic [4:0]       res_chan,
    output logic [RES_W-1:0] res_data,
    output logic             res_dup,
    output logic             res_grp_b,
    output logic             irq_scan_end,
    output logic             irq_grpb_end
);

    ctl_t ctl;
    logic start_flag;
    logic trig_a;
    logic sw_start, sw_stop;

    assign sw_start = reg_wr && reg_wdata[B_START];
    assign sw_stop  = reg_wr && !reg_wdata[B_START];

    adc_ctl_reg u_reg (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (reg_wr),
        .wr_data   (reg_wdata),
        .start_now (start_flag),
        .ctl       (ctl)
    );

    adc_trig_det u_trig (
        .clk        (clk),
        .rst        (rst),
        .pin_n      (ext_trig_n),
        .trig_pulse (trig_sync),
        .trig_en    (ctl.trig_en),
        .src_ext    (ctl.src_ext),
        .trig_a     (trig_a)
    );

    adc_scan_seq #(.NCH(NCH), .RES_W(RES_W)) u_seq (
        .clk          (clk),
        .rst          (rst),
        .ctl          (ctl),
        .wr_en        (reg_wr),
        .sw_start     (sw_start),
        .sw_stop      (sw_stop),
        .trig_a       (trig_a),
        .trig_b       (trig_grp_b),
        .mask_a       (mask_a),
        .mask_b       (mask_b),
        .conv_done    (conv_done),
        .conv_result  (conv_result),
        .conv_start   (conv_start),
        .conv_chan    (conv_chan),
        .res_valid    (res_valid),
        .res_chan     (res_chan),
        .res_data     (res_data),
        .res_dup      (res_dup),
        .res_grp_b    (res_grp_b),
        .irq_scan_end (irq_scan_end),
        .irq_grpb_end (irq_grpb_end),
        .start_flag   (start_flag)
    );

    assign reg_rdata = pack_ctl(ctl, start_flag);

endmodule

// File: rtl/adc_scan_chk.sv
module adc_scan_chk (
    input logic        clk,
    input logic        rst,
    input logic        reg_wr,
    input logic        wr_start,
    input logic [15:0] reg_rdata,
    input logic        conv_start,
    input logic        res_valid,
    input logic        res_dup,
    input logic        res_grp_b,
    input logic [4:0]  res_chan,
    input logic        irq_scan_end,
    input logic        irq_grpb_end
);

    AST_RSV_ZERO: assert property (@(posedge clk) disable iff (rst)
        (reg_rdata[5] == 1'b0) && (reg_rdata[11:10] == 2'b00)); // R2

    AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (rst)
        reg_rdata[14:13] != 2'b11); // R3

    AST_IRQ_A_GATED: assert property (@(posedge clk) disable iff (rst)
        irq_scan_end |-> reg_rdata[12]); // R5

    AST_IRQ_B_GATED: assert property (@(posedge clk) disable iff (rst)
        irq_grpb_end |-> reg_rdata[6]); // R5

    AST_START_SOURCE: assert property (@(posedge clk) disable iff (rst)
        $rose(reg_rdata[15]) |-> ($past(reg_wr) && $past(wr_start)) || $past(reg_rdata[9])); // R6

    AST_DUP_ONLY_DBL: assert property (@(posedge clk) disable iff (rst)
        (res_valid && res_dup) |-> (reg_rdata[7] && !res_grp_b)); // R10

    AST_DBL_CHANNEL: assert property (@(posedge clk) disable iff (rst)
        (res_valid && reg_rdata[7] && !res_grp_b) |-> (res_chan == reg_rdata[4:0])); // R10

    AST_DBLCH_HOLD: assert property (@(posedge clk) disable iff (rst)
        reg_rdata[15] |=> $stable(reg_rdata[4:0])); // R11

    AST_ONE_REQ: assert property (@(posedge clk) disable iff (rst)
        conv_start |=> !conv_start); // R14

endmodule

bind adc_scan_ctrl adc_scan_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .reg_wr       (reg_wr),
    .wr_start     (reg_wdata[15]),
    .reg_rdata    (reg_rdata),
    .conv_start   (conv_start),
    .res_valid    (res_valid),
    .res_dup      (res_dup),
    .res_grp_b    (res_grp_b),
    .res_chan     (res_chan),
    .irq_scan_end (irq_scan_end),
    .irq_grpb_end (irq_grpb_end)
);

// File: tb/sim_adc_scan_ctrl.sv
`timescale 1ns/1ps
module sim_adc_scan_ctrl;

    localparam int NCH   = 16;
    localparam int RES_W = 12;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             reg_wr = 1'b0;
    logic [15:0]      reg_wdata = '0;
    logic [15:0]      reg_rdata;
    logic             trig_sync = 1'b0;
    logic             trig_grp_b = 1'b0;
    logic             ext_trig_n = 1'b1;
    logic [NCH-1:0]   mask_a = 16'h00A1;
    logic [NCH-1:0]   mask_b = 16'h0006;
    logic             conv_start;
    logic [4:0]       conv_chan;
    logic             conv_done;
    logic [RES_W-1:0] conv_result;
    logic             res_valid;
    logic [4:0]       res_chan;
    logic [RES_W-1:0] res_data;
    logic             res_dup;
    logic             res_grp_b;
    logic             irq_scan_end;
    logic             irq_grpb_end;

    int n_chk = 0;
    int n_fail = 0;
    int n_irq_a = 0;
    int n_irq_b = 0;
    bit done = 1'b0;
    logic [6:0] expq[$];

    always #2 clk = ~clk;

    adc_scan_ctrl #(.NCH(NCH), .RES_W(RES_W)) u0 (.*);

    // converter stub: done three cycles after each request
    logic [1:0] stub_cnt;
    logic [4:0] stub_ch;
    logic [6:0] stub_seq;
    always @(posedge clk) begin
        if (rst) begin
            stub_cnt  <= '0;
            stub_ch   <= '0;
            stub_seq  <= '0;
            conv_done <= 1'b0;
            conv_result <= '0;
        end else begin
            conv_done <= 1'b0;
            if (stub_cnt != 0) begin
                stub_cnt <= stub_cnt - 2'd1;
                if (stub_cnt == 2'd1) begin
                    conv_done   <= 1'b1;
                    conv_result <= {stub_ch, stub_seq};
                    stub_seq    <= stub_seq + 7'd1;
                end
            end else if (conv_start) begin
                stub_cnt <= 2'd3;
                stub_ch  <= conv_chan;
            end
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst) begin
            if (irq_scan_end) n_irq_a++;
            if (irq_grpb_end) n_irq_b++;
            if (res_valid) begin
                if (expq.size() == 0) begin
                    check(1'b0, "R4/R6 unexpected result", {res_grp_b, res_dup, res_chan}, 0);
                end else begin
                    logic [6:0] it;
                    it = expq.pop_front();
                    check({res_grp_b, res_dup, res_chan} == it,
                          "R10/R12/R14 result tag", {res_grp_b, res_dup, res_chan}, it);
                    check(res_data[11:7] == it[4:0], "R14 result data", res_data[11:7], it[4:0]);
                end
            end
        end
    end

    task automatic push(input logic [4:0] ch, input bit dup, input bit gb);
        expq.push_back({gb, dup, ch});
    endtask

    task automatic push_a_scan();
        push(5'd0, 1'b0, 1'b0);
        push(5'd5, 1'b0, 1'b0);
        push(5'd7, 1'b0, 1'b0);
    endtask

    task automatic wr(input logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1;
        reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic pulse_sync();
        @(negedge clk); trig_sync = 1'b1;
        @(negedge clk); trig_sync = 1'b0;
    endtask

    task automatic pulse_b();
        @(negedge clk); trig_grp_b = 1'b1;
        @(negedge clk); trig_grp_b = 1'b0;
    endtask

    task automatic wait_a();
        repeat (8) @(negedge clk);
        for (int k = 0; k < 300 && reg_rdata[15]; k++) @(negedge clk);
        repeat (8) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int base;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(reg_rdata == 16'h0000, "R1 reset readback", reg_rdata, 16'h0000);
        check(!conv_start && !irq_scan_end, "R1 reset outputs", conv_start, 0);

        // R2 / R3: reserved bits and prohibited mode
        wr(16'h7C20);
        check(reg_rdata == 16'h1000, "R2 R3 reserved and bad mode", reg_rdata, 16'h1000);

        // R4 / R5 / R14: software single scan with interrupt
        push_a_scan();
        wr(16'h9000);
        check(reg_rdata[15] == 1'b1, "R4 start reads 1", reg_rdata[15], 1);
        wait_a();
        check(expq.size() == 0, "R14 scan complete", expq.size(), 0);
        check(n_irq_a == 1, "R5 irq with enable", n_irq_a, 1);
        check(reg_rdata == 16'h1000, "R4 start self-clears", reg_rdata, 16'h1000);

        // R5: interrupt disabled
        push_a_scan();
        wr(16'h8000);
        wait_a();
        check(n_irq_a == 1, "R5 irq gated off", n_irq_a, 1);

        // R6: triggers disabled
        wr(16'h0000);
        pulse_sync();
        repeat (30) @(negedge clk);
        check(reg_rdata[15] == 1'b0, "R6 sync trigger ignored", reg_rdata[15], 0);
        wr(16'h0100);
        @(negedge clk); ext_trig_n = 1'b0;
        repeat (2) @(negedge clk); ext_trig_n = 1'b1;
        repeat (30) @(negedge clk);
        check(reg_rdata[15] == 1'b0, "R6 pin ignored", reg_rdata[15], 0);

        // R7: synchronous trigger
        wr(16'h1200);
        push_a_scan();
        pulse_sync();
        wait_a();
        check(n_irq_a == 2, "R7 sync trigger scan", n_irq_a, 2);
        @(negedge clk); ext_trig_n = 1'b0;
        repeat (2) @(negedge clk); ext_trig_n = 1'b1;
        repeat (30) @(negedge clk);
        check(reg_rdata[15] == 1'b0, "R7 pin ignored in sync mode", reg_rdata[15], 0);

        // R7 / R8 / R9: asynchronous trigger armed while high
        wr(16'h1300);
        pulse_sync();
        repeat (10) @(negedge clk);
        check(reg_rdata[15] == 1'b0, "R7 sync ignored in pin mode", reg_rdata[15], 0);
        push_a_scan();
        @(negedge clk); ext_trig_n = 1'b0;
        repeat (2) @(negedge clk); ext_trig_n = 1'b1;
        repeat (2) @(negedge clk);
        check(reg_rdata[15] == 1'b1, "R9 two-cycle low recognised", reg_rdata[15], 1);
        wait_a();
        check(n_irq_a == 3, "R8 pin scan done", n_irq_a, 3);

        // R8: enabled while low, no start until high then low
        wr(16'h0000);
        @(negedge clk); ext_trig_n = 1'b0;
        repeat (10) @(negedge clk);
        wr(16'h1300);
        repeat (20) @(negedge clk);
        check(reg_rdata[15] == 1'b0, "R8 no start while low", reg_rdata[15], 0);
        ext_trig_n = 1'b1;
        repeat (5) @(negedge clk);
        push_a_scan();
        ext_trig_n = 1'b0;
        repeat (4) @(negedge clk);
        check(reg_rdata[15] == 1'b1, "R8 start after rearm", reg_rdata[15], 1);
        ext_trig_n = 1'b1;
        wait_a();

        // R10: double trigger on channel 3
        wr(16'h1283);
        push(5'd3, 1'b0, 1'b0); pulse_sync(); wait_a();
        push(5'd3, 1'b1, 1'b0); pulse_sync(); wait_a();
        push(5'd3, 1'b0, 1'b0); pulse_sync(); wait_a();
        check(expq.size() == 0, "R10 duplication sequence", expq.size(), 0);

        // R13: toggle reset by write with start 0, and by disabling
        wr(16'h1283);
        push(5'd3, 1'b0, 1'b0); pulse_sync(); wait_a();
        wr(16'h1203);
        wr(16'h1283);
        push(5'd3, 1'b0, 1'b0); pulse_sync(); wait_a();
        check(expq.size() == 0, "R13 toggle returns to first", expq.size(), 0);

        // R11: channel field locked on start write
        push(5'd3, 1'b1, 1'b0);
        wr(16'h9285);
        check(reg_rdata[4:0] == 5'd3, "R11 start write keeps channel", reg_rdata[4:0], 3);
        wait_a();

        // R3 / R4 / R11: continuous scan, locked channel, abort
        for (int k = 0; k < 8; k++) push(5'd3, k[0], 1'b0);
        base = n_irq_a;
        wr(16'hD283);
        wr(16'hD287);
        check(reg_rdata[4:0] == 5'd3, "R11 busy write keeps channel", reg_rdata[4:0], 3);
        check(reg_rdata[15:13] == 3'b110, "R3 continuous mode running", reg_rdata[15:13], 6);
        for (int k = 0; k < 400 && n_irq_a < base + 3; k++) @(negedge clk);
        check(n_irq_a >= base + 3, "R3 continuous restarts", n_irq_a - base, 3);
        wr(16'h1283);
        check(reg_rdata[15] == 1'b0, "R4 stop clears start", reg_rdata[15], 0);
        base = n_irq_a;
        repeat (30) @(negedge clk);
        check(n_irq_a == base, "R4 no irq after abort", n_irq_a - base, 0);
        expq.delete();

        // R12 / R5: group mode
        wr(16'h32C3);
        base = n_irq_a;
        push(5'd1, 1'b0, 1'b1); push(5'd2, 1'b0, 1'b1);
        pulse_b(); repeat (40) @(negedge clk);
        check(n_irq_b == 1 && n_irq_a == base, "R12 group B scan irq", n_irq_b, 1);
        push(5'd3, 1'b0, 1'b0); pulse_sync(); wait_a();
        push(5'd1, 1'b0, 1'b1); push(5'd2, 1'b0, 1'b1);
        pulse_b(); repeat (40) @(negedge clk);
        push(5'd3, 1'b1, 1'b0); pulse_sync(); wait_a();
        check(expq.size() == 0, "R12 group A duplicated, B not", expq.size(), 0);
        check(n_irq_b == 2 && n_irq_a == base + 2, "R5 group irq counts", n_irq_a - base, 2);

        wr(16'h3283);
        push(5'd1, 1'b0, 1'b1); push(5'd2, 1'b0, 1'b1);
        pulse_b(); repeat (40) @(negedge clk);
        check(n_irq_b == 2, "R5 group B irq gated off", n_irq_b, 2);
        check(expq.size() == 0, "R12 final queue empty", expq.size(), 0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule